// File: doc/BRIEF.md
# Region Access Firewall

The firewall sits in front of a memory target and decides, one request at a time, whether the target may see it. Each request carries a 32-bit address, the number of the input port it arrived on, the connection ID of the initiator that issued it, an access kind (read, write or instruction fetch), a privileged flag and a debug flag. Software programs up to nine address windows with 4 KB page bounds, plus an always-present background region. Each region has a set of per-port enables, a per-initiator read/write mask and a mask of allowed access modes. The highest-numbered region that covers the request decides whether it passes.

The block answers every request one cycle later with either a grant or an error. The first refused request is latched into an error log, which holds the region number, a packed description of the request and the faulting address. The log stays frozen, and an error-pending output stays high, until software writes the log register. A small update-control register gives software a busy flag and a flag that hardware raises whenever region configuration changes.

Top module: `addr_region_guard`

## Requirements
- R1: After reset no response is pending, `err_pending` is low and every register reads zero. Region 0 permissions are all clear, so every request is refused until software opens access.
- R2: A request sampled with `req_valid` high produces `rsp_valid` on the next cycle, together with exactly one of `rsp_grant` and `rsp_err`. Both are low when `rsp_valid` is low.
- R3: Regions 1 to 9 compare address bits [31:12] against a start page and an end page, both inclusive. The start word (offset 0x0 in the region slot) stores only bits [31:12] and reads zero below them. The end word (offset 0x4) stores the end page in bits [31:12].
- R4: Bits [2:0] of a region's end word enable that region for ports 0, 1 and 2. A region whose enable bit for the request port is clear, or any region for port number 3, is not considered.
- R5: Region 0 covers the whole address space for every port. Its start and end words read zero and ignore writes.
- R6: When several considered regions cover the address, the one with the highest number alone decides.
- R7: The initiator mask (slot offset 0xC) holds a read bit at position 2c and a write bit at position 2c+1 for connection ID c. A fetch uses the read bit. Connection ID 11 has no bits: positions 22 and 23 read zero and ignore writes, and ID 11 is always refused. IDs 13 to 15 are always refused.
- R8: The mode mask (slot offset 0x8) holds, from bit 0 up, user read, user write, user fetch, privileged read, privileged write, privileged fetch, user debug and privileged debug. A request passes only if both its mode bit and its initiator bit are set. Kind code 3 is always refused. The kind codes are 0 read, 1 write and 2 fetch.
- R9: A debug request is judged on the user-debug or privileged-debug bit in place of its kind bit. It still needs its initiator bit.
- R10: On a refusal with the log empty, the log word (address 0x000) captures the following fields. Bit 31 is the pending flag. Bits [21:17] and [16:12] both hold the deciding region number. Bits [11:0] hold the request information: bits [11:8] the connection ID, bit 7 set for writes, bit 3 debug, bit 1 privileged and bit 0 set for fetches, with the other bits zero. The address log (address 0x004, read-only) captures the full request address.
- R11: While the log holds an entry, `err_pending` stays high and later refusals leave both log words unchanged.
- R12: Any write to address 0x000 empties the error log and the address log. A refusal in the same cycle as that write is captured as the new entry.
- R13: At address 0x008, bit 0 is a busy flag that software reads and writes. Bit 1 is set by hardware on any write to a region slot, cleared by a software write with bit 1 at zero, and left unchanged by a write with bit 1 at one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_port | input | 2 | Input port number |
| req_conn | input | 4 | Initiator connection ID |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_priv | input | 1 | Privileged request |
| req_dbg | input | 1 | Debug request |
| rsp_valid | output | 1 | Decision for the previous cycle's request |
| rsp_grant | output | 1 | Request allowed |
| rsp_err | output | 1 | Request refused, error response |
| err_pending | output | 1 | Error log holds an entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
On every cycle, the bound checker enforces several properties: the one-cycle response timing, the exclusive grant/error pair, the refusal of connection ID 11, and the log lifecycle (set on a refusal, held until a clear, emptied by a clear with no new refusal). Only the bench's scenarios can show the rest: whether a decision is correct for a given region layout, including the inclusive page bounds, the port enables, the highest-number priority and the debug and fetch rules. The bench also covers the exact packing of the captured log word and the hardware-set/software-clear behaviour of the update flag.

// File: rtl/arg_pkg.sv
package arg_pkg;

  localparam int CONN_W       = 4;
  localparam int CONN_IDS     = 13;
  localparam int BLOCKED_CONN = 11;
  localparam int CONN_MASK_W  = 2 * CONN_IDS;
  localparam int MODE_W       = 8;
  localparam int INFO_W       = 12;
  localparam int LOG_RGN_W    = 5;

  // mode mask layout: user kinds at 0..2, privileged kinds at 3..4.., debug at 6/7
  localparam int MB_PRIV_OFS = 3;
  localparam int MB_UDBG     = 6;
  localparam int MB_PDBG     = 7;

  localparam logic [CONN_MASK_W-1:0] CONN_WRITABLE =
    ~(CONN_MASK_W'(2'b11) << (2 * BLOCKED_CONN));

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } req_kind_e;

  function automatic logic mode_allows(logic [MODE_W-1:0] m, req_kind_e k,
                                       logic priv, logic dbg);
    if (k == KIND_RSVD) return 1'b0;
    if (dbg) return priv ? m[MB_PDBG] : m[MB_UDBG];
    return m[(priv ? MB_PRIV_OFS : 0) + int'(k)];
  endfunction

  function automatic logic conn_allows(logic [CONN_MASK_W-1:0] m,
                                       logic [CONN_W-1:0] c, req_kind_e k);
    if (int'(c) >= CONN_IDS || int'(c) == BLOCKED_CONN) return 1'b0;
    return m[2 * int'(c) + ((k == KIND_WRITE) ? 1 : 0)];
  endfunction

  function automatic logic [INFO_W-1:0] pack_info(logic [CONN_W-1:0] c, req_kind_e k,
                                                  logic priv, logic dbg);
    return {c, (k == KIND_WRITE), 3'b000, dbg, 1'b0, priv, (k == KIND_FETCH)};
  endfunction

endpackage

// File: rtl/arg_regfile.sv
module arg_regfile
  import arg_pkg::*;
#(
  parameter int NUM_REGIONS = 10,
  parameter int NUM_PORTS   = 3,
  parameter int ADDR_W      = 32,
  parameter int PAGE_LSB    = 12,
  parameter int REG_AW      = 9,
  parameter int REGION_BASE = 256,
  parameter int UPD_ADDR    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [NUM_REGIONS-1:0][ADDR_W-PAGE_LSB-1:0] lo_pg,
  output logic [NUM_REGIONS-1:0][ADDR_W-PAGE_LSB-1:0] hi_pg,
  output logic [NUM_REGIONS-1:0][NUM_PORTS-1:0] port_en,
  output logic [NUM_REGIONS-1:0][MODE_W-1:0] mode_mask,
  output logic [NUM_REGIONS-1:0][CONN_MASK_W-1:0] conn_mask,
  output logic [31:0] cfg_rdata
);

  localparam int PAGE_W   = ADDR_W - PAGE_LSB;
  localparam int SLOT_AW  = REG_AW - 4;
  localparam logic [1:0] FLD_START = 2'd0;
  localparam logic [1:0] FLD_END   = 2'd1;
  localparam logic [1:0] FLD_MODE  = 2'd2;
  localparam logic [1:0] FLD_CONN  = 2'd3;

  function automatic logic slot_hit(logic [REG_AW-1:0] a, int r);
    return a[REG_AW-1:4] == SLOT_AW'(REGION_BASE / 16 + r);
  endfunction

  logic [NUM_REGIONS-1:0] slot_wr;
  logic busy_q;
  logic load_q;
  logic addr_lsb_unused;
  assign addr_lsb_unused = ^reg_addr[1:0];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_slot
    logic [MODE_W-1:0]      mode_q;
    logic [CONN_MASK_W-1:0] conn_q;
    assign slot_wr[r] = reg_wr && slot_hit(reg_addr, r);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= '0;
        conn_q <= '0;
      end else if (slot_wr[r]) begin
        if (reg_addr[3:2] == FLD_MODE) mode_q <= reg_wdata[MODE_W-1:0];
        if (reg_addr[3:2] == FLD_CONN) conn_q <= reg_wdata[CONN_MASK_W-1:0] & CONN_WRITABLE;
      end
    end
    assign mode_mask[r] = mode_q;
    assign conn_mask[r] = conn_q;

    if (r == 0) begin : g_background
      assign lo_pg[r]   = '0;
      assign hi_pg[r]   = '0;
      assign port_en[r] = '0;
    end else begin : g_window
      logic [PAGE_W-1:0]    lo_q;
      logic [PAGE_W-1:0]    hi_q;
      logic [NUM_PORTS-1:0] en_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
          en_q <= '0;
        end else if (slot_wr[r]) begin
          if (reg_addr[3:2] == FLD_START) lo_q <= reg_wdata[ADDR_W-1:PAGE_LSB];
          if (reg_addr[3:2] == FLD_END) begin
            hi_q <= reg_wdata[ADDR_W-1:PAGE_LSB];
            en_q <= reg_wdata[NUM_PORTS-1:0];
          end
        end
      end
      assign lo_pg[r]   = lo_q;
      assign hi_pg[r]   = hi_q;
      assign port_en[r] = en_q;
    end
  end

  // update control: busy is plain storage, load flag is set by hardware
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      load_q <= 1'b0;
    end else if (|slot_wr) begin
      load_q <= 1'b1;
    end else if (reg_wr && reg_addr[REG_AW-1:2] == (REG_AW-2)'(UPD_ADDR / 4)) begin
      busy_q <= reg_wdata[0];
      if (!reg_wdata[1]) load_q <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (reg_addr[REG_AW-1:2] == (REG_AW-2)'(UPD_ADDR / 4)) cfg_rdata = {30'd0, load_q, busy_q};
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (slot_hit(reg_addr, r)) begin
        case (reg_addr[3:2])
          FLD_START: cfg_rdata = 32'({lo_pg[r], {PAGE_LSB{1'b0}}});
          FLD_END:   cfg_rdata = 32'({hi_pg[r], {PAGE_LSB{1'b0}}}) | 32'(port_en[r]);
          FLD_MODE:  cfg_rdata = 32'(mode_mask[r]);
          default:   cfg_rdata = 32'(conn_mask[r]);
        endcase
      end
    end
  end

endmodule

// File: rtl/arg_region_match.sv
module arg_region_match #(
  parameter int NUM_REGIONS = 10,
  parameter int NUM_PORTS   = 3,
  parameter int PAGE_W      = 20,
  parameter int PORT_W      = 2,
  parameter int RIDX_W      = 4
) (
  input  logic [PAGE_W-1:0] req_pg,
  input  logic [PORT_W-1:0] req_port,
  input  logic [NUM_REGIONS-1:0][PAGE_W-1:0] lo_pg,
  input  logic [NUM_REGIONS-1:0][PAGE_W-1:0] hi_pg,
  input  logic [NUM_REGIONS-1:0][NUM_PORTS-1:0] port_en,
  output logic [NUM_REGIONS-1:0] hit,
  output logic [RIDX_W-1:0] win
);

  function automatic logic page_in_window(logic [PAGE_W-1:0] pg, logic [PAGE_W-1:0] lo,
                                          logic [PAGE_W-1:0] hi);
    return (pg >= lo) && (pg <= hi);
  endfunction

  logic port_known;
  assign port_known = int'(req_port) < NUM_PORTS;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_cmp
    if (r == 0) begin : g_all
      assign hit[r] = 1'b1;
    end else begin : g_win
      assign hit[r] = port_known && port_en[r][req_port]
                      && page_in_window(req_pg, lo_pg[r], hi_pg[r]);
    end
  end

  // highest-numbered covering region wins
  always_comb begin
    win = '0;
    for (int r = 0; r < NUM_REGIONS; r++)
      if (hit[r]) win = RIDX_W'(r);
  end

endmodule

// File: rtl/arg_err_log.sv
module arg_err_log
  import arg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RIDX_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic clear,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [RIDX_W-1:0] cap_region,
  input  logic [INFO_W-1:0] cap_info,
  output logic pending,
  output logic [ADDR_W-1:0] log_addr,
  output logic [RIDX_W-1:0] log_region,
  output logic [INFO_W-1:0] log_info
);

  logic take;
  assign take = capture && (!pending || clear);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      log_addr   <= '0;
      log_region <= '0;
      log_info   <= '0;
    end else if (take) begin
      pending    <= 1'b1;
      log_addr   <= cap_addr;
      log_region <= cap_region;
      log_info   <= cap_info;
    end else if (clear) begin
      pending    <= 1'b0;
      log_addr   <= '0;
      log_region <= '0;
      log_info   <= '0;
    end
  end

endmodule

// File: rtl/addr_region_guard.sv
module addr_region_guard
  import arg_pkg::*;
#(
  parameter int NUM_REGIONS = 10,
  parameter int NUM_PORTS   = 3,
  parameter int ADDR_W      = 32,
  parameter int PAGE_LSB    = 12,
  parameter int REG_AW      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_port,
  input  logic [CONN_W-1:0] req_conn,
  input  logic [1:0]        req_kind,
  input  logic              req_priv,
  input  logic              req_dbg,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_err,
  output logic              err_pending,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  localparam int PAGE_W      = ADDR_W - PAGE_LSB;
  localparam int RIDX_W      = $clog2(NUM_REGIONS);
  localparam int REGION_BASE = 256;
  localparam int ERR_ADDR    = 0;
  localparam int ALOG_ADDR   = 4;
  localparam int UPD_ADDR    = 8;

  logic [NUM_REGIONS-1:0][PAGE_W-1:0]      lo_pg;
  logic [NUM_REGIONS-1:0][PAGE_W-1:0]      hi_pg;
  logic [NUM_REGIONS-1:0][NUM_PORTS-1:0]   port_en;
  logic [NUM_REGIONS-1:0][MODE_W-1:0]      mode_mask;
  logic [NUM_REGIONS-1:0][CONN_MASK_W-1:0] conn_mask;
  logic [31:0] cfg_rdata;

  arg_regfile #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W),
    .PAGE_LSB(PAGE_LSB), .REG_AW(REG_AW), .REGION_BASE(REGION_BASE), .UPD_ADDR(UPD_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .lo_pg(lo_pg), .hi_pg(hi_pg), .port_en(port_en), .mode_mask(mode_mask),
    .conn_mask(conn_mask), .cfg_rdata(cfg_rdata)
  );

  logic [NUM_REGIONS-1:0] region_hit;
  logic [RIDX_W-1:0]      win_region;

  arg_region_match #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_PORTS(NUM_PORTS), .PAGE_W(PAGE_W),
    .PORT_W(2), .RIDX_W(RIDX_W)
  ) u_match (
    .req_pg(req_addr[ADDR_W-1:PAGE_LSB]), .req_port(req_port), .lo_pg(lo_pg),
    .hi_pg(hi_pg), .port_en(port_en), .hit(region_hit), .win(win_region)
  );

  // decision: both masks of the deciding region must agree
  req_kind_e kind;
  logic      mode_ok;
  logic      conn_ok;
  logic      allow;
  logic      violation;
  logic      log_clear;

  assign kind      = req_kind_e'(req_kind);
  assign mode_ok   = mode_allows(mode_mask[win_region], kind, req_priv, req_dbg);
  assign conn_ok   = conn_allows(conn_mask[win_region], req_conn, kind);
  assign allow     = mode_ok && conn_ok;
  assign violation = req_valid && !allow;
  assign log_clear = reg_wr && reg_addr[REG_AW-1:2] == (REG_AW-2)'(ERR_ADDR / 4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && allow;
      rsp_err   <= violation;
    end
  end

  logic [ADDR_W-1:0] log_addr;
  logic [RIDX_W-1:0] log_region;
  logic [INFO_W-1:0] log_info;

  arg_err_log #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_log (
    .clk(clk), .rst_n(rst_n), .capture(violation), .clear(log_clear),
    .cap_addr(req_addr), .cap_region(win_region),
    .cap_info(pack_info(req_conn, kind, req_priv, req_dbg)),
    .pending(err_pending), .log_addr(log_addr), .log_region(log_region), .log_info(log_info)
  );

  always_comb begin
    case (reg_addr[REG_AW-1:2])
      (REG_AW-2)'(ERR_ADDR / 4):
        reg_rdata = {err_pending, 9'd0, LOG_RGN_W'(log_region), LOG_RGN_W'(log_region), log_info};
      (REG_AW-2)'(ALOG_ADDR / 4):
        reg_rdata = 32'(log_addr);
      default:
        reg_rdata = cfg_rdata;
    endcase
  end

endmodule

// File: rtl/arg_checker.sv
module arg_checker
  import arg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CONN_W-1:0] req_conn,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic              rsp_err,
  input logic              err_pending,
  input logic              violation,
  input logic              log_clear,
  input logic [ADDR_W-1:0] log_addr
);

  assert_resp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_resp_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant != rsp_err));

  assert_resp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_grant && !rsp_err);

  assert_conn_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_conn == CONN_W'(BLOCKED_CONN) |=> rsp_err);

  assert_refusal_logged_R10: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> err_pending && rsp_err);

  assert_log_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pending && !log_clear |=> err_pending && $stable(log_addr));

  assert_log_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
    log_clear && !violation |=> !err_pending && log_addr == '0);

endmodule

bind addr_region_guard arg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_conn(req_conn),
  .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err(rsp_err),
  .err_pending(err_pending), .violation(violation), .log_clear(log_clear),
  .log_addr(log_addr)
);

// File: tb/sim_addr_region_guard.sv
`timescale 1ns/1ps
module sim_addr_region_guard;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] req_addr = 0;
  logic [1:0]  req_port = 0;
  logic [3:0]  req_conn = 0;
  logic [1:0]  req_kind = 0;
  logic        req_priv = 0;
  logic        req_dbg = 0;
  logic        rsp_valid, rsp_grant, rsp_err, err_pending;
  logic        reg_wr = 0;
  logic [8:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct { logic grant; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  addr_region_guard u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_port(req_port), .req_conn(req_conn), .req_kind(req_kind), .req_priv(req_priv),
    .req_dbg(req_dbg), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err(rsp_err),
    .err_pending(err_pending), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FX = 2'd2;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata === e, tag, reg_rdata, e);
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] p, input logic [3:0] c,
                      input logic [1:0] k, input logic pv, input logic d,
                      input logic g, input string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_port = p; req_conn = c;
    req_kind = k; req_priv = pv; req_dbg = d;
    sb.push_back('{g, tag});
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor: pop the scoreboard as decisions appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        chk(0, "R2 response without request", 32'(rsp_valid), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(rsp_grant === e.grant && rsp_err === !e.grant, e.tag,
            {30'd0, rsp_err, rsp_grant}, {30'd0, !e.grant, e.grant});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(err_pending === 0, "R1 err_pending", 32'(err_pending), 0);
    chk(rsp_valid === 0, "R1 rsp_valid", 32'(rsp_valid), 0);
    rd(9'h008, 0, "R1 update control");
    rd(9'h118, 0, "R1 region1 mode");
    send(32'h0000_4000, 0, 0, RD, 0, 0, 0, "R1 closed after reset");
    // R10 capture
    rd(9'h000, 32'h8000_0000, "R10 log word");
    rd(9'h004, 32'h0000_4000, "R10 address log");
    chk(err_pending === 1, "R11 pending", 32'(err_pending), 1);
    // R11 second refusal leaves log untouched
    send(32'h0000_8000, 1, 3, WR, 1, 0, 0, "R11 second refusal");
    rd(9'h000, 32'h8000_0000, "R11 log word held");
    rd(9'h004, 32'h0000_4000, "R11 address log held");
    // R12 clear
    wr(9'h000, 32'h0);
    rd(9'h000, 0, "R12 log cleared");
    rd(9'h004, 0, "R12 address log cleared");
    chk(err_pending === 0, "R12 pending dropped", 32'(err_pending), 0);
    // R13 update control
    rd(9'h008, 0, "R13 flag idle");
    wr(9'h108, 32'hFF);
    rd(9'h008, 32'h2, "R13 hardware set");
    wr(9'h008, 32'h3);
    rd(9'h008, 32'h3, "R13 busy set, flag kept");
    wr(9'h008, 32'h1);
    rd(9'h008, 32'h1, "R13 software clear");
    wr(9'h008, 32'h0);
    rd(9'h008, 32'h0, "R13 busy cleared");
    // region 0 background
    wr(9'h10C, 32'hFFFF_FFFF);
    rd(9'h10C, 32'h033F_FFFF, "R7 id 11 bits absent");
    wr(9'h100, 32'hFFFF_F000);
    wr(9'h104, 32'hFFFF_F007);
    rd(9'h100, 0, "R5 region0 start");
    rd(9'h104, 0, "R5 region0 end");
    send(32'h1234_5678, 2, 0, RD, 0, 0, 1, "R5 background port2");
    send(32'hFFFF_FFFC, 1, 12, FX, 1, 0, 1, "R5 background fetch");
    send(32'h1234_5678, 0, 11, RD, 0, 0, 0, "R7 id 11 refused");
    send(32'h1234_5678, 0, 13, RD, 0, 0, 0, "R7 id 13 refused");
    send(32'h1234_5678, 0, 0, 2'd3, 0, 0, 0, "R8 reserved kind");
    wr(9'h000, 0);
    // region 3: 0x2000_0000..0x2000_1FFF, port 0, user read/write, id2 read
    wr(9'h130, 32'h2000_0ABC);
    rd(9'h130, 32'h2000_0000, "R3 start low bits");
    wr(9'h134, 32'h2000_1001);
    rd(9'h134, 32'h2000_1001, "R4 end word enables");
    wr(9'h138, 32'h03);
    wr(9'h13C, 32'h10);
    send(32'h2000_1FFC, 0, 2, RD, 0, 0, 1, "R3 top page inclusive");
    send(32'h2000_0000, 0, 0, RD, 0, 0, 0, "R3 bottom page inclusive");
    send(32'h2000_2000, 0, 0, RD, 0, 0, 1, "R3 above window");
    send(32'h1FFF_FFFC, 0, 0, RD, 0, 0, 1, "R3 below window");
    send(32'h2000_0000, 0, 2, WR, 0, 0, 0, "R7 write bit missing");
    send(32'h2000_0000, 0, 2, RD, 1, 0, 0, "R8 privileged read bit missing");
    send(32'h2000_0000, 0, 2, FX, 0, 0, 0, "R8 user fetch bit missing");
    send(32'h2000_0000, 1, 0, RD, 0, 0, 1, "R4 port1 not enabled");
    send(32'h2000_0000, 3, 0, RD, 0, 0, 1, "R4 port3 background only");
    send(32'h2000_0000, 0, 2, RD, 0, 1, 0, "R9 user debug bit missing");
    wr(9'h138, 32'h43);
    send(32'h2000_0000, 0, 2, RD, 0, 1, 1, "R9 user debug allowed");
    send(32'h2000_0000, 0, 2, RD, 1, 1, 0, "R9 privileged debug bit missing");
    wr(9'h000, 0);
    // region 5 over the first page, region 2 under it
    wr(9'h150, 32'h2000_0000);
    wr(9'h154, 32'h2000_0001);
    wr(9'h158, 32'hFF);
    wr(9'h15C, 32'h3);
    wr(9'h120, 32'h2000_0000);
    wr(9'h124, 32'h2000_0001);
    send(32'h2000_0000, 0, 0, RD, 0, 0, 1, "R6 region5 over region3");
    send(32'h2000_0800, 0, 2, RD, 0, 0, 0, "R6 region5 refuses id2");
    send(32'h2000_1800, 0, 2, RD, 0, 0, 1, "R6 region3 outside region5");
    rd(9'h000, 32'h800A_5200, "R10 region and info fields");
    rd(9'h004, 32'h2000_0800, "R10 address");
    // R12 clear and refusal together
    @(negedge clk);
    reg_wr = 1; reg_addr = 9'h000; reg_wdata = 0;
    req_valid = 1; req_addr = 32'h2000_0400; req_port = 0; req_conn = 2;
    req_kind = WR; req_priv = 1; req_dbg = 1;
    sb.push_back('{1'b0, "R12 refusal during clear"});
    @(negedge clk);
    reg_wr = 0; req_valid = 0;
    rd(9'h000, 32'h800A_528A, "R12 new entry captured");
    rd(9'h004, 32'h2000_0400, "R12 new address captured");
    wr(9'h000, 0);
    chk(err_pending === 0, "R12 final clear", 32'(err_pending), 0);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R2 all responses seen", 32'(sb.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule